// File: doc/BRIEF.md
# Carry-Lookahead Add/Subtract ALU

A purely combinational arithmetic and logic unit for a 16-bit datapath. Two operands and a 3-bit opcode go in, and one result comes out. The unit adds, subtracts, and forms the bitwise AND, OR and exclusive-OR of its operands. The result settles within the same cycle, with no register on the way.

Both add and subtract use one shared adder. Its carries come from a two-level lookahead network. The lower level is a row of 4-bit lookahead groups. The upper level is one more lookahead group that combines their group generate and propagate terms.

Subtraction inverts the second operand through a 2-to-1 selection and forces the adder's carry-in high. Together these form the two's-complement negative. The per-bit generate and propagate gates of the adder also serve as the AND and OR results. The operand exclusive-OR serves both as the logical XOR result and as the first stage of the sum. A five-way one-hot selector picks the final result.

Top module: `claAlu`

## Requirements
- R1: Opcode 3'b000 gives result = (opA + opB) mod 2^16.
- R2: Opcode 3'b001 gives result = (opA - opB) mod 2^16, computed as opA plus the inverted opB with a carry-in of one.
- R3: Opcode 3'b010 gives result = opA & opB.
- R4: Opcode 3'b011 gives result = opA | opB.
- R5: Opcode 3'b100 gives result = opA ^ opB.
- R6: Opcodes 3'b101, 3'b110 and 3'b111 give an all-zero result.
- R7: A carry out of bit 15 is discarded, for example FFF0 + FFF0 = FFE0 and 0001 + FFFF = 0000, and carries cross every 4-bit group boundary.
- R8: The result depends only on the present inputs: after an input change it settles with no clock edge involved.
- R9: Subtraction boundaries hold: opA - 0000 = opA and 0000 - 0001 = FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand, or the subtrahend |
| opcode | input | 3 | Function select (see R1 to R6) |
| result | output | 16 | Combinational result |

## Verification
The bench builds the unit with its defaults: a width of 16 and groups of 4. This gives four lower groups feeding one upper group, so both lookahead levels are real. Directed pairs such as 0001 + FFFF and 0FFF + 0001 push a carry through every group boundary and through the upper group. Random operands under all eight opcodes cover the unused codes and the reuse of the generate and propagate terms for AND and OR.

// File: rtl/claAluPkg.sv
package claAluPkg;

  localparam int OPCODE_W   = 3;
  localparam int PICK_COUNT = 5;

  // one-hot positions in the result selector
  localparam int PICK_ADD = 0;
  localparam int PICK_SUB = 1;
  localparam int PICK_AND = 2;
  localparam int PICK_OR  = 3;
  localparam int PICK_XOR = 4;

  typedef enum logic [OPCODE_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100
  } aluOp_e;

  typedef struct packed {
    logic                  subtract;
    logic [PICK_COUNT-1:0] pick;
  } aluCtrl_t;

endpackage

// File: rtl/lookaheadGroup.sv
module lookaheadGroup #(
  parameter int N = 4
) (
  input  logic [N-1:0] gIn,
  input  logic [N-1:0] pIn,
  input  logic         carryIn,
  output logic         groupGen,
  output logic         groupProp,
  output logic [N-2:0] innerCarry
);

  // flat sum-of-products carry into position upto
  function automatic logic carryAt(input logic [N-1:0] g, input logic [N-1:0] p,
                                   input logic c0, input int upto);
    logic acc;
    logic term;
    acc = c0;
    for (int j = 0; j < upto; j++) acc = acc & p[j];
    for (int j = 0; j < upto; j++) begin
      term = g[j];
      for (int k = j + 1; k < upto; k++) term = term & p[k];
      acc = acc | term;
    end
    return acc;
  endfunction

  for (genvar i = 1; i < N; i++) begin : g_inner
    assign innerCarry[i-1] = carryAt(gIn, pIn, carryIn, i);
  end

  assign groupGen  = carryAt(gIn, pIn, 1'b0, N);
  assign groupProp = &pIn;

endmodule

// File: rtl/carryNetwork.sv
module carryNetwork #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] genBits,
  input  logic [WIDTH-1:0] propBits,
  input  logic             carryIn,
  output logic [WIDTH-1:0] carryOut
);

  localparam int NG = WIDTH / GROUP;

  logic [NG-1:0] grpG;
  logic [NG-1:0] grpP;
  logic [NG-1:0] grpCin;
  logic [NG-2:0] upperInner;
  logic          topG;
  logic          topP;

  // upper level: combines the group terms of the lower row
  lookaheadGroup #(.N(NG)) upper (
    .gIn       (grpG),
    .pIn       (grpP),
    .carryIn   (carryIn),
    .groupGen  (topG),
    .groupProp (topP),
    .innerCarry(upperInner)
  );

  assign grpCin = {upperInner, carryIn};

  for (genvar k = 0; k < NG; k++) begin : g_lower
    logic [GROUP-2:0] inner;

    lookaheadGroup #(.N(GROUP)) lower (
      .gIn       (genBits[k*GROUP +: GROUP]),
      .pIn       (propBits[k*GROUP +: GROUP]),
      .carryIn   (grpCin[k]),
      .groupGen  (grpG[k]),
      .groupProp (grpP[k]),
      .innerCarry(inner)
    );

    assign carryOut[k*GROUP +: GROUP-1] = inner;

    if (k == NG - 1) begin : g_last
      assign carryOut[k*GROUP + GROUP - 1] = topG | (topP & carryIn);
    end else begin : g_mid
      assign carryOut[k*GROUP + GROUP - 1] = grpCin[k+1];
    end
  end

endmodule

// File: rtl/aluControl.sv
module aluControl
  import claAluPkg::*;
(
  input  logic [OPCODE_W-1:0] opcode,
  output aluCtrl_t            ctrl
);

  always_comb begin
    ctrl = '0;
    case (opcode)
      OP_ADD: ctrl.pick[PICK_ADD] = 1'b1;
      OP_SUB: begin
        ctrl.subtract       = 1'b1;
        ctrl.pick[PICK_SUB] = 1'b1;
      end
      OP_AND: ctrl.pick[PICK_AND] = 1'b1;
      OP_OR:  ctrl.pick[PICK_OR]  = 1'b1;
      OP_XOR: ctrl.pick[PICK_XOR] = 1'b1;
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import claAluPkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result
);

  logic [WIDTH-1:0] invB;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] genBits;
  logic [WIDTH-1:0] propBits;
  logic [WIDTH-1:0] halfSum;
  logic [WIDTH-1:0] carryOut;
  logic [WIDTH-1:0] carryInto;
  logic [WIDTH-1:0] sumBits;
  logic             unusedMsbCarry;

  // negation: inversion here, the plus-one enters as carry-in
  assign invB   = ~opB;
  assign addend = ctrl.subtract ? invB : opB;

  assign genBits  = opA & addend;
  assign propBits = opA | addend;
  assign halfSum  = opA ^ addend;

  carryNetwork #(.WIDTH(WIDTH), .GROUP(GROUP)) carries (
    .genBits (genBits),
    .propBits(propBits),
    .carryIn (ctrl.subtract),
    .carryOut(carryOut)
  );

  assign carryInto      = {carryOut[WIDTH-2:0], ctrl.subtract};
  assign sumBits        = halfSum ^ carryInto;
  assign unusedMsbCarry = carryOut[WIDTH-1];

  logic [PICK_COUNT-1:0][WIDTH-1:0] paths;
  assign paths[PICK_ADD] = sumBits;
  assign paths[PICK_SUB] = sumBits;
  assign paths[PICK_AND] = genBits;
  assign paths[PICK_OR]  = propBits;
  assign paths[PICK_XOR] = halfSum;

  // AND-OR one-hot selector; no pick gives zero
  always_comb begin
    result = '0;
    for (int k = 0; k < PICK_COUNT; k++)
      result = result | (paths[k] & {WIDTH{ctrl.pick[k]}});
  end

endmodule

// File: rtl/claAlu.sv
module claAlu
  import claAluPkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0]    opA,
  input  logic [WIDTH-1:0]    opB,
  input  logic [OPCODE_W-1:0] opcode,
  output logic [WIDTH-1:0]    result
);

  aluCtrl_t ctrl;

  aluControl control (
    .opcode(opcode),
    .ctrl  (ctrl)
  );

  aluDatapath #(.WIDTH(WIDTH), .GROUP(GROUP)) datapath (
    .opA   (opA),
    .opB   (opB),
    .ctrl  (ctrl),
    .result(result)
  );

endmodule

// File: rtl/claAluCheck.sv
module claAluCheck #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opcode,
  input logic [WIDTH-1:0] result
);

  always_comb begin
    if (opcode == 3'b000)
      a_r1_add: assert (result == WIDTH'(opA + opB)) else $error("R1 add mismatch");
    if (opcode == 3'b001)
      a_r2_sub: assert (result == WIDTH'(opA - opB)) else $error("R2 sub mismatch");
    if (opcode == 3'b010)
      a_r3_and: assert (result == (opA & opB)) else $error("R3 and mismatch");
    if (opcode == 3'b011)
      a_r4_or: assert (result == (opA | opB)) else $error("R4 or mismatch");
    if (opcode == 3'b100)
      a_r5_xor: assert (result == (opA ^ opB)) else $error("R5 xor mismatch");
    if (opcode > 3'b100)
      a_r6_zero: assert (result == '0) else $error("R6 unused code not zero");
    if (opcode == 3'b001 && opB == '0)
      a_r9_sub_zero: assert (result == opA) else $error("R9 a minus zero");
  end

endmodule

bind claAlu claAluCheck #(.WIDTH(WIDTH)) chk (
  .opA   (opA),
  .opB   (opB),
  .opcode(opcode),
  .result(result)
);

// File: tb/claAlu_test.sv
`timescale 1ns/1ps
module claAlu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [2:0]  opcode = '0;
  logic [15:0] result;
  string       curTag = "R1";
  int          tests = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  claAlu uut (
    .opA(opA), .opB(opB), .opcode(opcode), .result(result)
  );

  function automatic logic [15:0] refModel(input logic [15:0] a, input logic [15:0] b,
                                           input logic [2:0] op);
    int v;
    case (op)
      3'd0: v = int'(a) + int'(b);
      3'd1: v = int'(a) - int'(b);
      3'd2: v = int'(a & b);
      3'd3: v = int'(a | b);
      3'd4: v = int'(a ^ b);
      default: v = 0;
    endcase
    return v[15:0];
  endfunction

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic checkNow(input string tag);
    logic [15:0] exp;
    exp = refModel(opA, opB, opcode);
    tests++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
               tag, opcode, opA, opB, result, exp);
    end
  endtask

  // compared against the model on every clock
  always @(negedge clk) if (!rst && !finished) checkNow(curTag);

  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic [2:0] op, input string tag);
    @(posedge clk);
    #1;
    opA = a; opB = b; opcode = op; curTag = tag;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // reset state: zero inputs, ADD, result zero
    tests++;
    if (result !== 16'h0000) begin
      fails++;
      $display("FAIL R1 reset actual=%h expected=0000", result);
    end
    rst = 1'b0;

    // R1 addition pairs, including sign mixes
    drive(16'h000F, 16'h000F, 3'd0, "R1");
    drive(16'h000F, 16'hFF00, 3'd0, "R1");
    drive(16'hFF00, 16'h000F, 3'd0, "R1");
    // R7 wrap and carries across all groups
    drive(16'hFFF0, 16'hFFF0, 3'd0, "R7");
    drive(16'h0001, 16'hFFFF, 3'd0, "R7");
    drive(16'h0FFF, 16'h0001, 3'd0, "R7");
    drive(16'h7FFF, 16'h0001, 3'd0, "R7");
    drive(16'h00FF, 16'h0001, 3'd0, "R7");
    // R2 subtraction pairs
    drive(16'h000F, 16'h000F, 3'd1, "R2");
    drive(16'hFFF0, 16'hFFF0, 3'd1, "R2");
    drive(16'h000F, 16'hFF00, 3'd1, "R2");
    drive(16'hFF00, 16'h000F, 3'd1, "R2");
    // R9 subtraction boundaries
    drive(16'h1234, 16'h0000, 3'd1, "R9");
    drive(16'h0000, 16'h0001, 3'd1, "R9");
    drive(16'h8000, 16'h0000, 3'd1, "R9");
    // R3, R4, R5 logic functions
    drive(16'h00FF, 16'h0F0F, 3'd2, "R3");
    drive(16'h00FF, 16'h0F0F, 3'd3, "R4");
    drive(16'h00FF, 16'h0F0F, 3'd4, "R5");
    // R6 unused codes give zero
    drive(16'hFFFF, 16'hFFFF, 3'd5, "R6");
    drive(16'hABCD, 16'h1234, 3'd6, "R6");
    drive(16'hFFFF, 16'h0001, 3'd7, "R6");

    // R8: change inputs mid-cycle, result follows without an edge
    @(negedge clk);
    #1;
    opA = 16'h0F0F; opB = 16'h0101; opcode = 3'd0; curTag = "R8";
    #0.5;
    checkNow("R8");
    opcode = 3'd1;
    #0.5;
    checkNow("R8");

    // random sweep over all opcodes
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      drive(16'($urandom), 16'($urandom), op, opTag(op));
    end

    @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule